// File: doc/BRIEF.md
# Block-Parallel Transposed FIR Filter

This block is a programmable FIR filter that handles several samples per clock. Each accepted input block carries `LANES` consecutive samples, and the filter returns the same number of filtered samples for every accepted block. The filter has `LANES*NBLK` taps in total. The datapath is a chain of `NBLK` block stages in transposed form. Each stage owns `LANES` consecutive taps. It multiplies those taps against a window of the current input block and the newest `LANES-1` samples of the previous block. It then adds the partial sums registered by the stage behind it and registers the total for the stage in front of it. Stage 0's register is the filter output.

Coefficients are written one at a time through a simple write port while the stream is idle. Samples and coefficients are signed two's complement values. The accumulator is a wider signed field, and sums wrap with no saturation or rounding. A flow flag travels with the data. The chain advances only on accepted blocks, and the output is flagged valid only once enough blocks have entered to fill every stage.

Top module: `tbf_filter`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0 and every lane of `y_blk` is 0; all coefficients reset to 0.
- R2: A write with `coef_we` high stores `coef_data` as tap `coef_addr`. Addresses 0 to `LANES*NBLK-1` are taps, and tap i weights the sample i positions older. A write to any address at or above `LANES*NBLK` changes no tap.
- R3: `out_valid` stays 0 for the first `NBLK-1` accepted blocks after reset. It is 1 in the cycle after the `NBLK`-th accepted block and in the cycle after every later accepted block.
- R4: The filtered block for an accepted input block appears on `y_blk` in the cycle right after the clock edge that accepted it, so one block is produced per clock under back-to-back input.
- R5: Each output sample is y(n) = sum over i of h(i)·x(n−i), with i from 0 to `LANES*NBLK-1`. Samples before the first accepted sample after reset count as zero.
- R6: Lane order on both sides: lane 0 (bits `[DW-1:0]` of `x_blk`, `[AW-1:0]` of `y_blk`) holds the newest sample n, and lane j holds sample n−j.
- R7: A cycle with `in_valid` low leaves the filter state unchanged. In the following cycle `out_valid` is 0 and `y_blk` holds its value, and the stream continues afterwards as if the idle cycle had not occurred.
- R8: Samples and taps are signed two's complement. Products of two most-negative values and mixed-sign products are accumulated with full sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_we | input | 1 | Tap write strobe |
| coef_addr | input | ADDRW | Tap index to write |
| coef_data | input | CW | Signed tap value |
| in_valid | input | 1 | Input block is presented and accepted this clock |
| x_blk | input | LANES*DW | Input block, lane 0 newest |
| out_valid | output | 1 | `y_blk` carries a fully primed output block |
| y_blk | output | LANES*AW | Output block, lane 0 newest |

## Verification
The hardest condition to reach from the ports is a bubble inside a primed chain. Stalls must freeze every stage's partial sums and the saved previous-block samples together, or the outputs that follow come out misaligned by one block. The stimulus primes the chain, inserts idle cycles of several lengths between accepted blocks, and then compares every later lane with a serial convolution of the sample history. It also checks that the output held steady during the gap. Writes to addresses past the last tap are sent in the middle of a test, and the impulse-like and extreme-value streams that follow show whether any tap was disturbed.

// File: rtl/tbf_pkg.sv
package tbf_pkg;

    // bits needed to index n entries, at least one
    function automatic int idx_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // bits needed to count from 0 up to n inclusive
    function automatic int cnt_bits(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/tbf_coef_bank.sv
module tbf_coef_bank #(
    parameter int TAPS  = 6,
    parameter int CW    = 8,
    parameter int ADDRW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDRW-1:0]     wr_addr,
    input  logic [CW-1:0]        wr_data,
    output logic [TAPS*CW-1:0]   taps
);

    typedef struct packed {
        logic [TAPS*CW-1:0] h;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < TAPS; i++) begin
            if (wr_en && (int'(wr_addr) == i)) begin
                bank_d.h[i*CW +: CW] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign taps = bank_q.h;

    AST_COEF_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_addr) >= TAPS)) |=> $stable(taps)); // R2

    AST_COEF_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(taps)); // R2

endmodule

// File: rtl/tbf_hist.sv
module tbf_hist #(
    parameter int LANES = 2,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    input  logic [LANES*DW-1:0]      cur,
    output logic [(LANES-1)*DW-1:0]  prev
);

    localparam int KEEP = LANES - 1;

    typedef struct packed {
        logic [KEEP*DW-1:0] s;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (adv) begin
            // the newest KEEP lanes are the ones the next window reaches back to
            hist_d.s = cur[KEEP*DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign prev = hist_q.s;

    AST_HIST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(prev)); // R7

    AST_HIST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (prev == $past(cur[KEEP*DW-1:0]))); // R5

endmodule

// File: rtl/tbf_tblk.sv
module tbf_tblk #(
    parameter int LANES = 2,
    parameter int DW    = 8,
    parameter int CW    = 8,
    parameter int AW    = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic [(2*LANES-1)*DW-1:0]   win,
    input  logic [LANES*CW-1:0]         coef,
    input  logic [LANES*AW-1:0]         psum_in,
    output logic [LANES*AW-1:0]         psum_q
);

    localparam int PW = DW + CW;
    localparam int XW = AW - PW;

    typedef struct packed {
        logic [LANES*AW-1:0] ps;
    } stage_t;

    stage_t stg_d, stg_q;

    logic signed [AW-1:0] acc;
    logic signed [PW-1:0] prod;

    // row j pairs tap k with window entry j+k (entry 0 = newest sample)
    always_comb begin
        stg_d = stg_q;
        acc   = '0;
        prod  = '0;
        if (en) begin
            for (int j = 0; j < LANES; j++) begin
                acc = $signed(psum_in[j*AW +: AW]);
                for (int k = 0; k < LANES; k++) begin
                    prod = $signed(win[(j+k)*DW +: DW]) * $signed(coef[k*CW +: CW]);
                    acc  = acc + $signed({{XW{prod[PW-1]}}, prod});
                end
                stg_d.ps[j*AW +: AW] = acc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign psum_q = stg_q.ps;

    AST_PSUM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(psum_q)); // R7

    AST_ZERO_TAPS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (coef == '0)) |=> (psum_q == $past(psum_in))); // R5

endmodule

// File: rtl/tbf_filter.sv
module tbf_filter
    import tbf_pkg::*;
#(
    parameter int LANES = 2,
    parameter int NBLK  = 3,
    parameter int DW    = 8,
    parameter int CW    = 8,
    parameter int AW    = 20,
    parameter int ADDRW = idx_bits(LANES * NBLK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   coef_we,
    input  logic [ADDRW-1:0]       coef_addr,
    input  logic [CW-1:0]          coef_data,
    input  logic                   in_valid,
    input  logic [LANES*DW-1:0]    x_blk,
    output logic                   out_valid,
    output logic [LANES*AW-1:0]    y_blk
);

    localparam int TAPS = LANES * NBLK;
    localparam int WINW = (2 * LANES - 1) * DW;
    localparam int FW   = cnt_bits(NBLK);

    typedef struct packed {
        logic [FW-1:0] fill;
        logic          vld;
    } flow_t;

    flow_t flow_d, flow_q;

    logic [TAPS*CW-1:0]  taps;
    logic [WINW-1:0]     win;
    logic [LANES*AW-1:0] chain [0:NBLK];

    tbf_coef_bank #(
        .TAPS  (TAPS),
        .CW    (CW),
        .ADDRW (ADDRW)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (coef_we),
        .wr_addr (coef_addr),
        .wr_data (coef_data),
        .taps    (taps)
    );

    generate
        if (LANES > 1) begin : g_hist
            logic [(LANES-1)*DW-1:0] prev;
            tbf_hist #(
                .LANES (LANES),
                .DW    (DW)
            ) u_hist (
                .clk   (clk),
                .rst_n (rst_n),
                .adv   (in_valid),
                .cur   (x_blk),
                .prev  (prev)
            );
            assign win = {prev, x_blk};
        end else begin : g_nohist
            assign win = x_blk;
        end
    endgenerate

    assign chain[NBLK] = '0;

    generate
        for (genvar m = 0; m < NBLK; m++) begin : g_stage
            tbf_tblk #(
                .LANES (LANES),
                .DW    (DW),
                .CW    (CW),
                .AW    (AW)
            ) u_tblk (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (in_valid),
                .win     (win),
                .coef    (taps[m*LANES*CW +: LANES*CW]),
                .psum_in (chain[m+1]),
                .psum_q  (chain[m])
            );
        end
    endgenerate

    always_comb begin
        flow_d     = flow_q;
        flow_d.vld = in_valid && (flow_q.fill >= FW'(NBLK - 1));
        if (in_valid && (flow_q.fill < FW'(NBLK))) begin
            flow_d.fill = flow_q.fill + FW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flow_q <= '0;
        end else begin
            flow_q <= flow_d;
        end
    end

    assign out_valid = flow_q.vld;
    assign y_blk     = chain[0];

    AST_VALID_ONLY_PRIMED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flow_q.fill == FW'(NBLK))); // R3

    AST_NO_VALID_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7

    AST_OUTPUT_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(y_blk)); // R7

    AST_PRIMED_FLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (flow_q.fill == FW'(NBLK))) |=> out_valid); // R4

endmodule

// File: tb/tb_tbf_filter.sv
module tb_tbf_filter;

    localparam int L     = 2;
    localparam int M     = 3;
    localparam int DW    = 8;
    localparam int CW    = 8;
    localparam int AW    = 20;
    localparam int T     = L * M;
    localparam int ADDRW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              coef_we = 1'b0;
    logic [ADDRW-1:0]  coef_addr = '0;
    logic [CW-1:0]     coef_data = '0;
    logic              in_valid = 1'b0;
    logic [L*DW-1:0]   x_blk = '0;
    logic              out_valid;
    logic [L*AW-1:0]   y_blk;

    int n_chk  = 0;
    int n_fail = 0;
    int h  [0:T-1];
    int xs [0:4095];
    int ns   = 0;
    int nacc = 0;
    int unsigned seed = 32'h1234_5678;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tbf_filter #(
        .LANES (L),
        .NBLK  (M),
        .DW    (DW),
        .CW    (CW),
        .AW    (AW),
        .ADDRW (ADDRW)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .coef_we   (coef_we),
        .coef_addr (coef_addr),
        .coef_data (coef_data),
        .in_valid  (in_valid),
        .x_blk     (x_blk),
        .out_valid (out_valid),
        .y_blk     (y_blk)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint ref_y(input int n);
        longint s = 0;
        for (int i = 0; i < T; i++) begin
            if (n - i >= 0) s += longint'(h[i]) * longint'(xs[n-i]);
        end
        return s;
    endfunction

    function automatic longint lane_y(input int j);
        return longint'($signed(y_blk[j*AW +: AW]));
    endfunction

    function automatic int next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[23:16]));
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; coef_we = 1'b0;
        ns = 0; nacc = 0;
        for (int i = 0; i < T; i++) h[i] = 0;
        for (int i = 0; i < 4096; i++) xs[i] = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_tap(input int a, input int v);
        coef_we = 1'b1; coef_addr = ADDRW'(a); coef_data = CW'(v);
        @(negedge clk);
        coef_we = 1'b0;
        if (a < T) h[a] = v;
    endtask

    task automatic load_taps(input int v0, input int v1, input int v2,
                             input int v3, input int v4, input int v5);
        write_tap(0, v0); write_tap(1, v1); write_tap(2, v2);
        write_tap(3, v3); write_tap(4, v4); write_tap(5, v5);
    endtask

    // xs[ns .. ns+L-1] must be filled; lane i carries the sample at ns+L-1-i
    task automatic push_block(input string req);
        for (int i = 0; i < L; i++) x_blk[i*DW +: DW] = DW'(xs[ns+L-1-i]);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        ns += L;
        nacc++;
        if (nacc < M) begin
            check(out_valid == 1'b0, "R3", longint'(out_valid), 0);
        end else begin
            check(out_valid == 1'b1, "R3", longint'(out_valid), 1);
            for (int j = 0; j < L; j++) begin
                check(lane_y(j) == ref_y(ns - 1 - j), req, lane_y(j), ref_y(ns - 1 - j));
            end
        end
    endtask

    task automatic push_rand(input int nblk, input string req);
        for (int b = 0; b < nblk; b++) begin
            for (int i = 0; i < L; i++) xs[ns+i] = next_rand();
            push_block(req);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", longint'(out_valid), 0);
        check(y_blk == '0, "R1", longint'(y_blk), 0);
        do_reset();
        check(out_valid == 1'b0, "R1", longint'(out_valid), 0);
        check(y_blk == '0, "R1", longint'(y_blk), 0);
        // taps reset to zero: a full stream must produce all-zero output
        h[0] = 0;
        push_rand(M + 1, "R1");
    endtask

    task automatic t_impulse();
        do_reset();
        load_taps(1, 2, 3, 4, 5, 6);
        xs[0] = 1;
        // lane order: single unit sample shows up as taps in age order
        for (int b = 0; b < 6; b++) push_block("R6");
    endtask

    task automatic t_stream();
        do_reset();
        load_taps(-3, 7, 12, 12, 7, -3);
        push_rand(20, "R5");
        do_reset();
        load_taps(5, -9, 0, 31, -17, 2);
        push_rand(20, "R4");
    endtask

    task automatic t_idle();
        logic [L*AW-1:0] held;
        do_reset();
        load_taps(2, -1, 4, 3, -6, 1);
        push_rand(M + 1, "R5");
        for (int g = 1; g <= 3; g++) begin
            held = y_blk;
            for (int c = 0; c < g; c++) begin
                @(negedge clk);
                check(out_valid == 1'b0, "R7", longint'(out_valid), 0);
                check(y_blk == held, "R7", longint'(y_blk), longint'(held));
            end
            push_rand(2, "R7");
        end
    endtask

    task automatic t_oor_write();
        do_reset();
        load_taps(1, -2, 3, -4, 5, -6);
        push_rand(M, "R2");
        write_tap(6, 99);
        write_tap(7, -77);
        push_rand(6, "R2");
    endtask

    task automatic t_extremes();
        do_reset();
        load_taps(-128, 127, -128, -128, 127, -128);
        for (int i = 0; i < 8 * L; i++) xs[i] = (i % 3 == 2) ? 127 : -128;
        for (int b = 0; b < 8; b++) push_block("R8");
    endtask

    initial begin
        t_reset();
        t_impulse();
        t_stream();
        t_idle();
        t_oor_write();
        t_extremes();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule